// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block tracks instructions from dispatch to retirement in program order. It keeps a ring of entries. Dispatch can claim up to four consecutive entries per cycle. Execution units report results against an entry's tag in any order, and each report can flag an exception. Every cycle the block looks at the oldest four entries. It retires the longest finished, exception-free run from the oldest one onward, and it raises one write-back strobe for each retired entry.

Exceptions are precise. An entry with an exception stops retirement in front of it. When that entry becomes the oldest, the block does not retire it. Instead it reports the exception with the entry's tag and empties the ring. A mispredict flush names a tag. Every entry younger than that tag is dropped, and retirement in the same cycle cannot go past it.

Tags are a slot index with one extra wrap bit, so a full ring and an empty ring look different. The block answers a dispatch request it cannot take with a stall output and allocates nothing.

Top module: `inorder_retire_buf`

## Requirements
- R1: After reset the ring is empty. `disp_tag` and `ret_tag` are 0, `ret_valid` and `exc_valid` are low, and a request for WIDTH entries does not stall.
- R2: An accepted request for n entries (n = 0..WIDTH) assigns tags `disp_tag`, `disp_tag`+1 … `disp_tag`+n-1, counted modulo 2·DEPTH. In the next cycle `disp_tag` has advanced by n.
- R3: A request larger than the number of free entries raises `disp_stall` and allocates nothing. Free entries are DEPTH minus the occupancy at the start of the cycle.
- R4: A finish report sets the finished state, and the exception flag, of the live entry whose tag matches. A report whose tag lies outside the live window (tag minus `ret_tag`, modulo 2·DEPTH, not below the occupancy) has no effect, even when its slot index matches a live entry.
- R5: `ret_valid` bit i means that entry `ret_tag`+i retires this cycle. The set bits always form a run starting at bit 0, and the next `ret_tag` equals the current one plus the number of set bits.
- R6: Retirement stops at the first unfinished entry of the oldest WIDTH entries and never goes past the occupancy.
- R7: When the oldest entry is finished with an exception, `exc_valid` rises with `exc_tag` equal to its tag and nothing retires. In the next cycle the ring is empty and `disp_tag` equals `ret_tag`. This takes priority over a flush in the same cycle.
- R8: A finished entry with an exception that is not the oldest blocks retirement of itself and of every entry after it. Older finished entries still retire.
- R9: A flush naming a live tag drops every entry younger than that tag and keeps the named entry. In the next cycle `disp_tag` is the flush tag plus 1. A flush naming a tag outside the live window is ignored.
- R10: In a flush cycle, retirement covers at most the entries up to and including the flush tag.
- R11: A non-zero dispatch request in a cycle with a flush or an exception report stalls.
- R12: The occupancy never exceeds DEPTH. With DEPTH entries live, `disp_tag` and `ret_tag` differ only in the wrap bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_cnt | input | CNT_W | Number of entries requested this cycle (0..WIDTH) |
| disp_stall | output | 1 | Request refused this cycle |
| disp_tag | output | TAG_W | Tag given to the first entry of an accepted request |
| fin_valid | input | NFIN | Finish report valid, one bit per reporting port |
| fin_tag | input | NFIN*TAG_W | Tag of each report, port k in bits [k*TAG_W +: TAG_W] |
| fin_exc | input | NFIN | The reported instruction raised an exception |
| flush_req | input | 1 | Mispredict flush request |
| flush_tag | input | TAG_W | Youngest tag kept by the flush |
| ret_valid | output | WIDTH | Write-back strobe for entry `ret_tag`+i |
| ret_tag | output | TAG_W | Tag of the oldest live entry |
| exc_valid | output | 1 | The oldest entry carries an exception; the ring is emptied |
| exc_tag | output | TAG_W | Tag of the excepting entry |

## Verification
The bench builds the block with its defaults: DEPTH 16, WIDTH 4 and two finish ports. With these values four full-width dispatches fill the ring, so stall on a full ring and stall on partial space both occur within a few cycles. Tags run past DEPTH into the second lap of the wrap bit, where a report for tag 30 lands on the same slot as the live tag 14 and has to be ignored. Two finish ports let a single cycle finish one entry in order and another out of order. They also let a cycle pair a finish with a flush or with an exception, so each ordering rule can be tested on its own.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

  // Length of the unbroken run of ones starting at bit 0, looking at n bits.
  function automatic int unsigned lead_run(input logic [15:0] v, input int unsigned n);
    int unsigned c;
    logic go;
    c = 0;
    go = 1'b1;
    for (int unsigned i = 0; i < 16; i++) begin
      if (i < n && go) begin
        if (v[i]) c = c + 1;
        else      go = 1'b0;
      end
    end
    return c;
  endfunction

  // Thermometer mask with the low n bits set.
  function automatic logic [15:0] low_mask(input int unsigned n);
    logic [15:0] m;
    m = '0;
    for (int unsigned i = 0; i < 16; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction

  // Distance from an older tag to a younger one, modulo the tag space.
  function automatic logic [7:0] tag_gap(input logic [7:0] younger, input logic [7:0] older);
    return younger - older;
  endfunction

endpackage

// File: rtl/cbuf_slots.sv
module cbuf_slots #(
  parameter int DEPTH = 16,
  parameter int NFIN  = 2,
  parameter int IDX_W = 4,
  parameter int TAG_W = 5,
  parameter int CNT_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TAG_W-1:0]        head_tag,
  input  logic [TAG_W-1:0]        tail_tag,
  input  logic [TAG_W-1:0]        occ,
  input  logic [CNT_W-1:0]        alloc_n,
  input  logic [NFIN-1:0]         fin_valid,
  input  logic [NFIN*TAG_W-1:0]   fin_tag,
  input  logic [NFIN-1:0]         fin_exc,
  output logic [DEPTH-1:0]        done_vec,
  output logic [DEPTH-1:0]        exc_vec
);
  import cbuf_pkg::*;

  logic [DEPTH-1:0] clr, set_d, set_x;

  always_comb begin
    clr   = '0;
    set_d = '0;
    set_x = '0;
    for (int s = 0; s < DEPTH; s++) begin
      logic [IDX_W-1:0] rel;
      rel = IDX_W'(s) - tail_tag[IDX_W-1:0];
      clr[s] = ({{(TAG_W-IDX_W){1'b0}}, rel} < TAG_W'(alloc_n));
    end
    for (int p = 0; p < NFIN; p++) begin
      logic [TAG_W-1:0] t, gap;
      t   = fin_tag[p*TAG_W +: TAG_W];
      gap = TAG_W'(tag_gap(8'(t), 8'(head_tag)));
      if (fin_valid[p] && gap < occ) begin
        set_d[t[IDX_W-1:0]] = 1'b1;
        if (fin_exc[p]) set_x[t[IDX_W-1:0]] = 1'b1;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          done_vec[g] <= 1'b0;
          exc_vec[g]  <= 1'b0;
        end else if (clr[g]) begin
          done_vec[g] <= 1'b0;
          exc_vec[g]  <= 1'b0;
        end else if (set_d[g]) begin
          done_vec[g] <= 1'b1;
          exc_vec[g]  <= set_x[g];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/cbuf_retire_sel.sv
module cbuf_retire_sel #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 4,
  parameter int IDX_W = 4,
  parameter int TAG_W = 5,
  parameter int CNT_W = 3
) (
  input  logic [TAG_W-1:0] head_tag,
  input  logic [TAG_W-1:0] occ,
  input  logic [DEPTH-1:0] done_vec,
  input  logic [DEPTH-1:0] exc_vec,
  input  logic             flush_req,
  input  logic [TAG_W-1:0] flush_tag,
  output logic [WIDTH-1:0] ret_mask,
  output logic [CNT_W-1:0] ret_cnt,
  output logic             exc_hit,
  output logic             flush_hit
);
  import cbuf_pkg::*;

  logic [TAG_W-1:0] fl_off;
  logic [WIDTH-1:0] ok;
  logic [IDX_W-1:0] hidx;
  int unsigned      run;

  assign hidx      = head_tag[IDX_W-1:0];
  assign fl_off    = TAG_W'(tag_gap(8'(flush_tag), 8'(head_tag)));
  assign flush_hit = flush_req && (fl_off < occ);
  assign exc_hit   = (occ != '0) && done_vec[hidx] && exc_vec[hidx];

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      logic [IDX_W-1:0] slot;
      slot  = hidx + IDX_W'(i);
      ok[i] = (TAG_W'(i) < occ) && done_vec[slot] && !exc_vec[slot] &&
              (!flush_hit || TAG_W'(i) <= fl_off);
    end
    run      = lead_run(16'(ok), WIDTH);
    ret_cnt  = CNT_W'(run);
    ret_mask = WIDTH'(low_mask(run));
  end

endmodule

// File: rtl/cbuf_ptrs.sv
module cbuf_ptrs #(
  parameter int TAG_W = 5,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] ret_cnt,
  input  logic [CNT_W-1:0] alloc_n,
  input  logic             exc_hit,
  input  logic             flush_hit,
  input  logic [TAG_W-1:0] flush_tag,
  output logic [TAG_W-1:0] head_tag,
  output logic [TAG_W-1:0] tail_tag
);
  logic [TAG_W-1:0] head_d, tail_d;

  always_comb begin
    head_d = head_tag + TAG_W'(ret_cnt);
    if (exc_hit)        tail_d = head_tag;
    else if (flush_hit) tail_d = flush_tag + TAG_W'(1);
    else                tail_d = tail_tag + TAG_W'(alloc_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_tag <= '0;
      tail_tag <= '0;
    end else begin
      head_tag <= head_d;
      tail_tag <= tail_d;
    end
  end

endmodule

// File: rtl/inorder_retire_buf.sv
module inorder_retire_buf #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 4,
  parameter int NFIN  = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int TAG_W = IDX_W + 1,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CNT_W-1:0]      disp_cnt,
  output logic                  disp_stall,
  output logic [TAG_W-1:0]      disp_tag,
  input  logic [NFIN-1:0]       fin_valid,
  input  logic [NFIN*TAG_W-1:0] fin_tag,
  input  logic [NFIN-1:0]       fin_exc,
  input  logic                  flush_req,
  input  logic [TAG_W-1:0]      flush_tag,
  output logic [WIDTH-1:0]      ret_valid,
  output logic [TAG_W-1:0]      ret_tag,
  output logic                  exc_valid,
  output logic [TAG_W-1:0]      exc_tag
);
  logic [TAG_W-1:0] head_tag, tail_tag, occ, free_n;
  logic [DEPTH-1:0] done_vec, exc_vec;
  logic [CNT_W-1:0] ret_cnt, alloc_n;
  logic             exc_hit, flush_hit, no_room;

  assign occ        = tail_tag - head_tag;
  assign free_n     = TAG_W'(DEPTH) - occ;
  assign no_room    = TAG_W'(disp_cnt) > free_n;
  assign disp_stall = (disp_cnt != '0) && (no_room || exc_hit || flush_req);
  assign alloc_n    = disp_stall ? '0 : disp_cnt;

  assign disp_tag  = tail_tag;
  assign ret_tag   = head_tag;
  assign exc_valid = exc_hit;
  assign exc_tag   = head_tag;

  cbuf_slots #(.DEPTH(DEPTH), .NFIN(NFIN), .IDX_W(IDX_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .head_tag(head_tag), .tail_tag(tail_tag), .occ(occ),
    .alloc_n(alloc_n), .fin_valid(fin_valid), .fin_tag(fin_tag), .fin_exc(fin_exc),
    .done_vec(done_vec), .exc_vec(exc_vec)
  );

  cbuf_retire_sel #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IDX_W(IDX_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_sel (
    .head_tag(head_tag), .occ(occ), .done_vec(done_vec), .exc_vec(exc_vec),
    .flush_req(flush_req), .flush_tag(flush_tag), .ret_mask(ret_valid),
    .ret_cnt(ret_cnt), .exc_hit(exc_hit), .flush_hit(flush_hit)
  );

  cbuf_ptrs #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .ret_cnt(ret_cnt), .alloc_n(alloc_n), .exc_hit(exc_hit),
    .flush_hit(flush_hit), .flush_tag(flush_tag), .head_tag(head_tag), .tail_tag(tail_tag)
  );

endmodule

// File: rtl/cbuf_checker.sv
module cbuf_checker #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 4,
  parameter int TAG_W = 5,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TAG_W-1:0] occ,
  input logic [TAG_W-1:0] head_tag,
  input logic [TAG_W-1:0] tail_tag,
  input logic [CNT_W-1:0] disp_cnt,
  input logic             disp_stall,
  input logic [WIDTH-1:0] ret_valid,
  input logic [CNT_W-1:0] ret_cnt,
  input logic             exc_valid,
  input logic             flush_req,
  input logic             flush_hit,
  input logic [TAG_W-1:0] flush_tag
);
  logic [TAG_W-1:0] rc_w, dc_w;
  assign rc_w = TAG_W'(ret_cnt);
  assign dc_w = TAG_W'(disp_cnt);

  assert_occ_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= TAG_W'(DEPTH));

  assert_ret_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ret_valid + WIDTH'(1)) & ret_valid) == '0);

  assert_head_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> head_tag == $past(head_tag) + $past(rc_w));

  assert_ret_within_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rc_w <= occ);

  assert_exc_noret_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> ret_valid == '0);

  assert_exc_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> occ == '0);

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_stall && !exc_valid && !flush_hit) |=> $stable(tail_tag));

  assert_alloc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_stall && !exc_valid && !flush_req) |=> tail_tag == $past(tail_tag) + $past(dc_w));

  assert_flush_tail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_hit && !exc_valid) |=> tail_tag == $past(flush_tag) + TAG_W'(1));

endmodule

bind inorder_retire_buf cbuf_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .occ(occ), .head_tag(head_tag), .tail_tag(tail_tag),
  .disp_cnt(disp_cnt), .disp_stall(disp_stall), .ret_valid(ret_valid), .ret_cnt(ret_cnt),
  .exc_valid(exc_valid), .flush_req(flush_req), .flush_hit(flush_hit), .flush_tag(flush_tag)
);

// File: tb/inorder_retire_buf_tb.sv
`timescale 1ns/1ps
module inorder_retire_buf_tb;
  localparam int TAG_W = 5;
  localparam int NV    = 30;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       disp_cnt = '0;
  logic             disp_stall;
  logic [TAG_W-1:0] disp_tag;
  logic [1:0]       fin_valid = '0;
  logic [9:0]       fin_tag = '0;
  logic [1:0]       fin_exc = '0;
  logic             flush_req = 1'b0;
  logic [TAG_W-1:0] flush_tag = '0;
  logic [3:0]       ret_valid;
  logic [TAG_W-1:0] ret_tag;
  logic             exc_valid;
  logic [TAG_W-1:0] exc_tag;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  inorder_retire_buf u_dut (
    .clk(clk), .rst_n(rst_n), .disp_cnt(disp_cnt), .disp_stall(disp_stall), .disp_tag(disp_tag),
    .fin_valid(fin_valid), .fin_tag(fin_tag), .fin_exc(fin_exc), .flush_req(flush_req),
    .flush_tag(flush_tag), .ret_valid(ret_valid), .ret_tag(ret_tag), .exc_valid(exc_valid),
    .exc_tag(exc_tag)
  );

  // Vector: req, two finish reports (valid, tag, exc), flush (valid, tag),
  // then expected stall, disp_tag, ret_valid, ret_tag, exc_valid.
  function automatic logic [38:0] v(int rq, int av, int at, int ae, int bv, int bt, int be,
                                    int fl, int ft, int st, int dt, int rt, int hd, int ex);
    return {3'(rq), 1'(av), 5'(at), 1'(ae), 1'(bv), 5'(bt), 1'(be), 1'(fl), 5'(ft),
            1'(st), 5'(dt), 4'(rt), 5'(hd), 1'(ex)};
  endfunction

  localparam logic [38:0] VEC [NV] = '{
    v(4, 0,0,0,  0,0,0,   0,0, 0, 0,4'b0000, 0,0),  // R2 first group 0..3
    v(4, 1,2,0,  1,0,0,   0,0, 0, 4,4'b0000, 0,0),  // R4 out of order finish
    v(0, 1,1,0,  0,0,0,   0,0, 0, 8,4'b0001, 0,0),  // R6 stops at entry 1
    v(0, 0,0,0,  0,0,0,   0,0, 0, 8,4'b0011, 1,0),  // R5
    v(4, 1,3,0,  1,4,0,   0,0, 0, 8,4'b0000, 3,0),
    v(4, 1,6,1,  1,5,0,   0,0, 0,12,4'b0011, 3,0),  // R8 exc recorded on 6
    v(4, 0,0,0,  0,0,0,   0,0, 0,16,4'b0001, 5,0),  // R8 stops before 6
    v(4, 0,0,0,  0,0,0,   0,0, 1,20,4'b0000, 6,1),  // R7 R11 R3
    v(3, 0,0,0,  0,0,0,   0,0, 0, 6,4'b0000, 6,0),  // R7 ring emptied
    v(0, 0,0,0,  0,0,0,   0,0, 0, 9,4'b0000, 6,0),  // stale state cleared
    v(4, 1,6,0,  1,7,0,   0,0, 0, 9,4'b0000, 6,0),
    v(0, 1,9,0,  1,10,0,  0,0, 0,13,4'b0011, 6,0),
    v(0, 1,8,0,  0,0,0,   0,0, 0,13,4'b0000, 8,0),
    v(2, 0,0,0,  0,0,0,   1,9, 1,13,4'b0011, 8,0),  // R10 R11 limit at flush tag
    v(0, 0,0,0,  0,0,0,   0,0, 0,10,4'b0000,10,0),  // R9 tail = flush+1
    v(4, 0,0,0,  0,0,0,   0,0, 0,10,4'b0000,10,0),
    v(4, 0,0,0,  0,0,0,   0,0, 0,14,4'b0000,10,0),
    v(4, 0,0,0,  0,0,0,   0,0, 0,18,4'b0000,10,0),
    v(4, 0,0,0,  0,0,0,   0,0, 0,22,4'b0000,10,0),
    v(1, 0,0,0,  0,0,0,   0,0, 1,26,4'b0000,10,0),  // R12 R3 full ring
    v(0, 1,11,0, 1,25,0,  0,0, 0,26,4'b0000,10,0),
    v(0, 1,10,0, 1,30,0,  0,0, 0,26,4'b0000,10,0),  // R4 tag 30 outside window
    v(0, 0,0,0,  0,0,0,   0,0, 0,26,4'b0011,10,0),
    v(0, 1,12,0, 1,13,0,  0,0, 0,26,4'b0000,12,0),
    v(3, 0,0,0,  0,0,0,   0,0, 1,26,4'b0011,12,0),  // R3 free counted at cycle start
    v(3, 0,0,0,  0,0,0,   0,0, 0,26,4'b0000,14,0),  // R4 entry 14 untouched
    v(0, 1,15,0, 1,16,0,  0,0, 0,29,4'b0000,14,0),
    v(0, 1,17,0, 1,14,0,  0,0, 0,29,4'b0000,14,0),
    v(0, 0,0,0,  0,0,0,   0,0, 0,29,4'b1111,14,0),  // R5 full width retire
    v(0, 0,0,0,  0,0,0,   0,0, 0,29,4'b0000,18,0)
  };

  task automatic chk(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic drive(int rq, int av, int at, int ae, int bv, int bt, int be, int fl, int ft);
    disp_cnt  = 3'(rq);
    fin_valid = {1'(bv), 1'(av)};
    fin_tag   = {5'(bt), 5'(at)};
    fin_exc   = {1'(be), 1'(ae)};
    flush_req = 1'(fl);
    flush_tag = 5'(ft);
  endtask

  task automatic idle();
    drive(0, 0,0,0, 0,0,0, 0,0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [2:0] rq; logic av, ae, bv, be, fl, st, ex;
    logic [4:0] at, bt, ft, dt, hd; logic [3:0] rt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    drive(4, 0,0,0, 0,0,0, 0,0);
    #1;
    chk("R1", "disp_stall", int'(disp_stall), 0);
    chk("R1", "disp_tag", int'(disp_tag), 0);
    chk("R1", "ret_tag", int'(ret_tag), 0);
    chk("R1", "ret_valid", int'(ret_valid), 0);
    chk("R1", "exc_valid", int'(exc_valid), 0);
    // keep the ring empty for the table: request withdrawn before the edge
    idle();
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      {rq, av, at, ae, bv, bt, be, fl, ft, st, dt, rt, hd, ex} = VEC[k];
      drive(int'(rq), int'(av), int'(at), int'(ae), int'(bv), int'(bt), int'(be), int'(fl), int'(ft));
      #1;
      chk("R3", $sformatf("v%0d disp_stall", k), int'(disp_stall), int'(st));
      chk("R2", $sformatf("v%0d disp_tag", k), int'(disp_tag), int'(dt));
      chk("R5", $sformatf("v%0d ret_valid", k), int'(ret_valid), int'(rt));
      chk("R6", $sformatf("v%0d ret_tag", k), int'(ret_tag), int'(hd));
      chk("R7", $sformatf("v%0d exc_valid", k), int'(exc_valid), int'(ex));
      if (ex) chk("R7", $sformatf("v%0d exc_tag", k), int'(exc_tag), int'(hd));
      @(negedge clk);
    end
    idle();

    // R1 reset from a busy state
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "disp_tag after reset", int'(disp_tag), 0);
    chk("R1", "ret_tag after reset", int'(ret_tag), 0);
    @(negedge clk);

    // R7 exception at the oldest entry wins over a flush in the same cycle
    drive(2, 0,0,0, 0,0,0, 0,0);
    @(negedge clk);
    drive(0, 1,0,1, 0,0,0, 0,0);
    @(negedge clk);
    drive(0, 0,0,0, 0,0,0, 1,0);
    #1;
    chk("R7", "exc_valid with flush", int'(exc_valid), 1);
    chk("R7", "exc_tag", int'(exc_tag), 0);
    chk("R7", "no retire on exception", int'(ret_valid), 0);
    @(negedge clk);
    idle();
    #1;
    chk("R7", "disp_tag after drain", int'(disp_tag), 0);
    chk("R7", "exc_valid after drain", int'(exc_valid), 0);

    // R9 flush naming a tag outside the live window is ignored
    drive(3, 0,0,0, 0,0,0, 0,0);
    @(negedge clk);
    drive(0, 0,0,0, 0,0,0, 1,20);
    @(negedge clk);
    idle();
    #1;
    chk("R9", "dead flush tag ignored", int'(disp_tag), 3);
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule